// File: doc/BRIEF.md
# LIN Slave Response Engine

This block is the byte-level frame engine of a LIN slave node. It sits after the break and sync detection logic. It starts when that logic signals that a header has been synchronised. The first byte that follows is the protected identifier. The engine checks its two parity bits and then reads a per-identifier entry from an on-chip table. That entry says whether the node publishes the response, subscribes to it, or stays silent. It also gives the response length and the checksum model. The frame itself carries no length or direction, so this table is the only source of both.

When the node publishes, the engine hands bytes one at a time to a UART transmitter and waits for each byte to come back on the receive path before sending the next. The final byte is the checksum. When the node subscribes, the engine collects the data bytes into a shadow buffer and verifies the checksum that follows. Only a frame that checks out is copied to the application-facing buffer. Diagnostic identifiers use a fixed length and checksum model, and reserved identifiers are never answered. A bit-time watchdog abandons a response that stalls.

Top module: `lin_frame_proc`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tx_start`, `rx_done`, `tx_done` and all four error outputs are 0, and `sub_data` is all zeros.
- R2: The protected identifier carries the frame ID in bits 5:0. Bit 6 must equal ID0^ID1^ID2^ID4 and bit 7 must equal the inverse of ID1^ID3^ID4^ID5. On a mismatch, `err_parity` pulses and the frame is neither answered nor collected.
- R3: Each table entry is 6 bits, written through `cfg_we`/`cfg_id`/`cfg_wdata`. Bits [1:0] hold the mode (00 ignore, 01 subscribe, 10 publish, 11 ignore). Bits [4:2] hold the data length minus one. Bit 5 selects the enhanced checksum. An ignored ID produces no transmission, no pulse and no change of `sub_data`.
- R4: A subscribed frame with a correct checksum produces a one-cycle `rx_done` pulse after its checksum byte. On that pulse, `sub_data` holds data byte k in bits 8k+7:8k, bytes beyond the length are zero, and `frame_id` holds the ID.
- R5: The checksum is the bitwise inverse of an 8-bit sum with end-around carry. The classic model sums the data bytes only; the enhanced model also sums the protected identifier. On a mismatch, `err_cksum` pulses and `sub_data` keeps its previous value.
- R6: A published frame sends the data bytes from `pub_data` (byte k from bits 8k+7:8k), then the checksum. Each byte uses one `tx_start` pulse, and the next pulse comes only after the previous byte has been read back. `tx_done` pulses after the checksum is read back.
- R7: If a read-back byte differs from the byte sent, `err_bit` pulses and no further byte of that frame is transmitted.
- R8: IDs 0x3C and 0x3D always use 8 data bytes and the classic checksum, whatever length and model their table entry holds.
- R9: IDs 0x3E and 0x3F are never answered or collected, whatever their table entry holds.
- R10: Once the response phase begins, `err_timeout` pulses on the `bit_tick` that completes TO_BITS ticks without the response finishing, and the frame is dropped. One tick fewer has no effect.
- R11: A `hdr_start` pulse at any point drops the frame in progress without an error and waits for a new protected identifier.
- R12: At most one of `rx_done`, `tx_done` and the four error outputs is high in any cycle, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_start | input | 1 | Header synchronised; next received byte is the protected identifier |
| rx_valid | input | 1 | Received byte strobe from the UART receiver |
| rx_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per bit time |
| cfg_we | input | 1 | Table write enable |
| cfg_id | input | 6 | Table write address (frame ID) |
| cfg_wdata | input | 6 | Table entry to write |
| pub_data | input | 8*MAX_BYTES | Response bytes to publish |
| tx_start | output | 1 | Start transmitting `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| sub_data | output | 8*MAX_BYTES | Last correctly received response |
| frame_id | output | 6 | ID of the current or last frame |
| rx_done | output | 1 | Subscribed frame accepted |
| tx_done | output | 1 | Published frame completed |
| err_parity | output | 1 | Identifier parity failure |
| err_cksum | output | 1 | Received checksum mismatch |
| err_bit | output | 1 | Read-back mismatch while publishing |
| err_timeout | output | 1 | Response did not finish in time |

## Verification
The assertions watch, on every cycle, that completion and error pulses are exclusive and single-cycle, that `sub_data` changes only with an accepted frame, that transmit strobes never come back to back and stop after a read-back error, and that a timeout only ever follows a bit tick. Checksum arithmetic, parity decoding, table-driven direction and length, the diagnostic and reserved overrides, and the exact tick count of the timeout can only be shown by the bench. It does this by sending whole frames and comparing each result with values computed from the requirements.

// File: rtl/lin_fp_pkg.sv
package lin_fp_pkg;

  typedef enum logic [1:0] {
    MODE_IGNORE = 2'b00,
    MODE_SUB    = 2'b01,
    MODE_PUB    = 2'b10,
    MODE_OFF    = 2'b11
  } mode_e;

  // table entry: [5] enhanced, [4:2] length-1, [1:0] mode
  typedef struct packed {
    logic       enh;
    logic [2:0] len_m1;
    mode_e      mode;
  } cfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PID, S_LOOK, S_SEND, S_ECHO, S_RECV
  } st_e;

  // 8-bit add with end-around carry
  function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_id_table.sv
module lin_id_table #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lin_pid_check.sv
module lin_pid_check (
  input  logic [7:0] pid,
  output logic [5:0] id,
  output logic       ok,
  output logic       reserved
);
  logic p_even, p_odd;

  always_comb begin
    id       = pid[5:0];
    p_even   = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
    p_odd    = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
    ok       = (pid[6] == p_even) && (pid[7] == p_odd);
    reserved = (pid[5:1] == 5'b11111);   // 0x3E, 0x3F
  end
endmodule

// File: rtl/lin_frame_proc.sv
module lin_frame_proc
  import lin_fp_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int TO_BITS   = 140
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hdr_start,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  input  logic                   bit_tick,
  input  logic                   cfg_we,
  input  logic [5:0]             cfg_id,
  input  logic [5:0]             cfg_wdata,
  input  logic [8*MAX_BYTES-1:0] pub_data,
  output logic                   tx_start,
  output logic [7:0]             tx_byte,
  output logic [8*MAX_BYTES-1:0] sub_data,
  output logic [5:0]             frame_id,
  output logic                   rx_done,
  output logic                   tx_done,
  output logic                   err_parity,
  output logic                   err_cksum,
  output logic                   err_bit,
  output logic                   err_timeout
);
  localparam int SEL_W = $clog2(MAX_BYTES);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);
  localparam int CNT_W = $clog2(TO_BITS + 1);

  st_e              state;
  logic [7:0]       pid_q, sum_q, sent_q;
  logic [IDX_W-1:0] idx_q, len_q;
  logic [CNT_W-1:0] to_cnt;
  logic [7:0]       shadow [MAX_BYTES];
  logic [7:0]       pub_b  [MAX_BYTES];

  logic [5:0] pc_id;
  logic       pc_ok, pc_rsv;
  logic [5:0] tbl_rdata;
  cfg_t       cfg_rd;
  logic       tbl_re, active, diag, tick_out;

  genvar g;
  generate
    for (g = 0; g < MAX_BYTES; g++) begin : g_pub
      assign pub_b[g] = pub_data[8*g +: 8];
    end
  endgenerate

  lin_pid_check u_pid (
    .pid(rx_byte), .id(pc_id), .ok(pc_ok), .reserved(pc_rsv)
  );

  assign tbl_re = (state == S_PID) && rx_valid && !hdr_start;

  lin_id_table #(.ADDR_W(6), .DATA_W(6)) u_tbl (
    .clk(clk), .we(cfg_we), .waddr(cfg_id), .wdata(cfg_wdata),
    .re(tbl_re), .raddr(rx_byte[5:0]), .rdata(tbl_rdata)
  );

  assign cfg_rd   = cfg_t'(tbl_rdata);
  assign active   = (state == S_SEND) || (state == S_ECHO) || (state == S_RECV);
  assign diag     = (frame_id[5:1] == 5'b11110);            // 0x3C, 0x3D
  assign tick_out = active && bit_tick && (to_cnt == CNT_W'(TO_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      pid_q       <= '0;
      sum_q       <= '0;
      sent_q      <= '0;
      idx_q       <= '0;
      len_q       <= '0;
      to_cnt      <= '0;
      tx_start    <= 1'b0;
      tx_byte     <= '0;
      sub_data    <= '0;
      frame_id    <= '0;
      rx_done     <= 1'b0;
      tx_done     <= 1'b0;
      err_parity  <= 1'b0;
      err_cksum   <= 1'b0;
      err_bit     <= 1'b0;
      err_timeout <= 1'b0;
      for (int k = 0; k < MAX_BYTES; k++) shadow[k] <= '0;
    end else begin
      tx_start    <= 1'b0;
      rx_done     <= 1'b0;
      tx_done     <= 1'b0;
      err_parity  <= 1'b0;
      err_cksum   <= 1'b0;
      err_bit     <= 1'b0;
      err_timeout <= 1'b0;
      if (active && bit_tick) to_cnt <= to_cnt + CNT_W'(1);

      if (hdr_start) begin
        state <= S_PID;
      end else if (tick_out) begin
        err_timeout <= 1'b1;
        state       <= S_IDLE;
      end else begin
        case (state)
          S_PID: if (rx_valid) begin
            if (!pc_ok) begin
              err_parity <= 1'b1;
              state      <= S_IDLE;
            end else if (pc_rsv) begin
              state <= S_IDLE;
            end else begin
              pid_q    <= rx_byte;
              frame_id <= pc_id;
              state    <= S_LOOK;
            end
          end
          S_LOOK: begin
            to_cnt <= '0;
            idx_q  <= '0;
            len_q  <= diag ? IDX_W'(MAX_BYTES) : IDX_W'(cfg_rd.len_m1) + IDX_W'(1);
            sum_q  <= (cfg_rd.enh && !diag) ? pid_q : 8'h00;
            for (int k = 0; k < MAX_BYTES; k++) shadow[k] <= '0;
            case (cfg_rd.mode)
              MODE_SUB: state <= S_RECV;
              MODE_PUB: state <= S_SEND;
              default:  state <= S_IDLE;
            endcase
          end
          S_SEND: begin
            tx_start <= 1'b1;
            tx_byte  <= (idx_q == len_q) ? ~sum_q : pub_b[idx_q[SEL_W-1:0]];
            sent_q   <= (idx_q == len_q) ? ~sum_q : pub_b[idx_q[SEL_W-1:0]];
            state    <= S_ECHO;
          end
          S_ECHO: if (rx_valid) begin
            if (rx_byte != sent_q) begin
              err_bit <= 1'b1;
              state   <= S_IDLE;
            end else if (idx_q == len_q) begin
              tx_done <= 1'b1;
              state   <= S_IDLE;
            end else begin
              sum_q <= cks_add(sum_q, rx_byte);
              idx_q <= idx_q + IDX_W'(1);
              state <= S_SEND;
            end
          end
          S_RECV: if (rx_valid) begin
            if (idx_q == len_q) begin
              if (rx_byte == ~sum_q) begin
                rx_done <= 1'b1;
                for (int k = 0; k < MAX_BYTES; k++) sub_data[8*k +: 8] <= shadow[k];
              end else begin
                err_cksum <= 1'b1;
              end
              state <= S_IDLE;
            end else begin
              shadow[idx_q[SEL_W-1:0]] <= rx_byte;
              sum_q <= cks_add(sum_q, rx_byte);
              idx_q <= idx_q + IDX_W'(1);
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_frame_proc_chk.sv
module lin_frame_proc_chk #(
  parameter int MAX_BYTES = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bit_tick,
  input logic                   tx_start,
  input logic                   rx_done,
  input logic                   tx_done,
  input logic                   err_parity,
  input logic                   err_cksum,
  input logic                   err_bit,
  input logic                   err_timeout,
  input logic [8*MAX_BYTES-1:0] sub_data
);
  // R1: outputs are quiet on the cycle after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!tx_start && !rx_done && !tx_done && !err_parity && !err_cksum && !err_bit && !err_timeout));

  // R12: completion and error events are exclusive
  p_one_event_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_done, tx_done, err_parity, err_cksum, err_bit, err_timeout}));

  // R12: completion pulse lasts one cycle
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (rx_done || tx_done) |=> (!rx_done && !tx_done));

  // R5: application buffer only moves with an accepted frame
  p_sub_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rx_done |-> $stable(sub_data));

  // R6: each byte waits for its read-back, so strobes never abut
  p_tx_gap_r6: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  // R7: transmission stops after a read-back mismatch
  p_bit_stop_r7: assert property (@(posedge clk) disable iff (rst)
    err_bit |=> !tx_start);

  // R10: a timeout is always caused by a bit tick
  p_timeout_tick_r10: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> $past(bit_tick));
endmodule

bind lin_frame_proc lin_frame_proc_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_start(tx_start),
  .rx_done(rx_done), .tx_done(tx_done), .err_parity(err_parity),
  .err_cksum(err_cksum), .err_bit(err_bit), .err_timeout(err_timeout),
  .sub_data(sub_data)
);

// File: tb/lin_frame_proc_bench.sv
`timescale 1ns/1ps
module lin_frame_proc_bench;
  localparam int NB    = 8;
  localparam int TB_TO = 140;
  localparam int K_RX = 0, K_TX = 1, K_PAR = 2, K_CK = 3, K_BIT = 4, K_TO = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_start = 0, rx_valid = 0, bit_tick = 0, cfg_we = 0;
  logic [7:0] rx_byte = 0;
  logic [5:0] cfg_id = 0, cfg_wdata = 0;
  logic [8*NB-1:0] pub_data = 0;
  logic tx_start, rx_done, tx_done, err_parity, err_cksum, err_bit, err_timeout;
  logic [7:0] tx_byte;
  logic [8*NB-1:0] sub_data;
  logic [5:0] frame_id;

  always #4 clk = ~clk;   // 125 MHz

  lin_frame_proc #(.MAX_BYTES(NB), .TO_BITS(TB_TO)) u_lin_frame_proc (
    .clk(clk), .rst(rst), .hdr_start(hdr_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .bit_tick(bit_tick), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_wdata(cfg_wdata),
    .pub_data(pub_data), .tx_start(tx_start), .tx_byte(tx_byte), .sub_data(sub_data),
    .frame_id(frame_id), .rx_done(rx_done), .tx_done(tx_done), .err_parity(err_parity),
    .err_cksum(err_cksum), .err_bit(err_bit), .err_timeout(err_timeout)
  );

  int checks = 0, fails = 0, tx_seen = 0;
  int              exp_kind [$];
  logic [5:0]      exp_id   [$];
  logic [8*NB-1:0] exp_data [$];
  string           exp_req  [$];
  logic [8*NB-1:0] last_sub = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mkpid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] mkcks(input logic [7:0] pid, input bit enh,
                                       input int n, input logic [63:0] d);
    int s;
    s = enh ? int'(pid) : 0;
    for (int k = 0; k < n; k++) begin
      s = s + int'(d[8*k +: 8]);
      if (s > 255) s = s - 255;
    end
    return ~s[7:0];
  endfunction

  function automatic logic [63:0] trim(input int n, input logic [63:0] d);
    logic [63:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic expect_ev(input int kind, input logic [5:0] id,
                           input logic [63:0] d, input string req);
    exp_kind.push_back(kind); exp_id.push_back(id);
    exp_data.push_back(d);    exp_req.push_back(req);
  endtask

  task automatic cfg(input logic [5:0] id, input logic [1:0] mode,
                     input int len, input bit enh);
    @(negedge clk);
    cfg_we = 1; cfg_id = id;
    cfg_wdata = {enh, 3'(len - 1), mode};
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic header(input logic [7:0] pid);
    @(negedge clk); hdr_start = 1;
    @(negedge clk); hdr_start = 0;
    send_byte(pid);
  endtask

  task automatic settle(input string req);
    repeat (6) @(negedge clk);
    chk(exp_kind.size() == 0, req, "pending expected events", 64'(exp_kind.size()), 64'd0);
  endtask

  task automatic sub_frame(input logic [5:0] id, input int n, input bit enh,
                           input logic [63:0] d, input bit good, input string req);
    logic [7:0] pid, ck;
    pid = mkpid(id);
    ck  = mkcks(pid, enh, n, d);
    if (good) begin
      last_sub = trim(n, d);
      expect_ev(K_RX, id, last_sub, req);
    end else begin
      expect_ev(K_CK, id, last_sub, req);
    end
    header(pid);
    for (int k = 0; k < n; k++) send_byte(d[8*k +: 8]);
    send_byte(good ? ck : ck ^ 8'h10);
    settle(req);
  endtask

  task automatic pub_frame(input logic [5:0] id, input int n, input bit enh,
                           input logic [63:0] d, input int bad_k, input string req);
    logic [7:0] pid, ck, want;
    int w, base;
    pid = mkpid(id);
    ck  = mkcks(pid, enh, n, d);
    pub_data = d;
    expect_ev(bad_k < 0 ? K_TX : K_BIT, id, last_sub, req);
    header(pid);
    for (int k = 0; k <= n; k++) begin
      w = 0;
      while (!tx_start && w < 50) begin @(negedge clk); w++; end
      chk(tx_start == 1'b1, req, "tx_start seen", 64'(tx_start), 64'd1);
      want = (k == n) ? ck : d[8*k +: 8];
      chk(tx_byte == want, req, "transmitted byte", 64'(tx_byte), 64'(want));
      rx_valid = 1;
      rx_byte  = (k == bad_k) ? tx_byte ^ 8'h04 : tx_byte;
      @(negedge clk); rx_valid = 0;
      if (k == bad_k) break;
    end
    base = tx_seen;
    settle(req);
    if (bad_k >= 0)
      chk(tx_seen == base, "R7", "transmits after read-back error", 64'(tx_seen - base), 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      int kind;
      if (tx_start) tx_seen++;
      if (rx_done || tx_done || err_parity || err_cksum || err_bit || err_timeout) begin
        kind = rx_done ? K_RX : tx_done ? K_TX : err_parity ? K_PAR :
               err_cksum ? K_CK : err_bit ? K_BIT : K_TO;
        if (exp_kind.size() == 0) begin
          chk(1'b0, "R3", "unexpected event", 64'(kind), 64'hFF);
        end else begin
          int ek; logic [5:0] eid; logic [63:0] ed; string er;
          ek = exp_kind.pop_front(); eid = exp_id.pop_front();
          ed = exp_data.pop_front(); er = exp_req.pop_front();
          chk(kind == ek, er, "event kind", 64'(kind), 64'(ek));
          if (ek == K_RX || ek == K_CK)
            chk(sub_data == ed, er, "sub_data", sub_data, ed);
          if (ek == K_RX || ek == K_TX)
            chk(frame_id == eid, er, "frame_id", 64'(frame_id), 64'(eid));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] keep;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    chk({tx_start, rx_done, tx_done, err_parity, err_cksum, err_bit, err_timeout} == 7'd0,
        "R1", "flags in reset", 64'({tx_start, rx_done, tx_done}), 64'd0);
    rst = 0;
    @(negedge clk);
    chk(sub_data == '0, "R1", "sub_data after reset", sub_data, 64'd0);
    chk(tx_start == 1'b0, "R1", "tx_start after reset", 64'(tx_start), 64'd0);

    for (int i = 0; i < 64; i++) cfg(6'(i), 2'b00, 1, 1'b0);
    cfg(6'h10, 2'b01, 2, 1'b0);
    cfg(6'h11, 2'b01, 8, 1'b1);
    cfg(6'h20, 2'b10, 3, 1'b0);
    cfg(6'h21, 2'b10, 5, 1'b1);
    cfg(6'h05, 2'b11, 4, 1'b0);
    cfg(6'h3E, 2'b01, 1, 1'b0);
    cfg(6'h3C, 2'b01, 1, 1'b1);

    // R4 R5: classic subscribe, carry-producing data
    sub_frame(6'h10, 2, 1'b0, 64'h0000_0000_0000_F0E5, 1'b1, "R4");
    // R5: enhanced subscribe, 8 bytes
    sub_frame(6'h11, 8, 1'b1, 64'hFF80_7F01_C3A5_5AFE, 1'b1, "R5");
    // R5: checksum mismatch keeps old data
    sub_frame(6'h10, 2, 1'b0, 64'h0000_0000_0000_1234, 1'b0, "R5");
    // R6: publish classic and enhanced
    pub_frame(6'h20, 3, 1'b0, 64'h0000_0000_00FF_FF02, -1, "R6");
    pub_frame(6'h21, 5, 1'b1, 64'h0000_0099_8877_6655, -1, "R6");
    // R7: corrupted read-back
    pub_frame(6'h20, 3, 1'b0, 64'h0000_0000_0033_2211, 1, "R7");

    // R2: bad parity
    expect_ev(K_PAR, 6'h10, last_sub, "R2");
    header(mkpid(6'h10) ^ 8'h40);
    send_byte(8'h01);
    settle("R2");

    // R3: ignored ID
    keep = sub_data;
    header(mkpid(6'h05));
    for (int k = 0; k < 5; k++) send_byte(8'h00);
    settle("R3");
    chk(sub_data == keep, "R3", "sub_data after ignored frame", sub_data, keep);

    // R9: reserved ID configured as subscribe
    keep = sub_data;
    header(mkpid(6'h3E));
    send_byte(8'h42);
    send_byte(mkcks(mkpid(6'h3E), 1'b0, 1, 64'h42));
    settle("R9");
    chk(sub_data == keep, "R9", "sub_data after reserved frame", sub_data, keep);

    // R8: diagnostic ID overrides length and checksum model
    sub_frame(6'h3C, 8, 1'b0, 64'h0102_0304_0506_0708, 1'b1, "R8");

    // R11: new header mid-response
    header(mkpid(6'h11));
    send_byte(8'hAA);
    sub_frame(6'h10, 2, 1'b0, 64'h0000_0000_0000_7766, 1'b1, "R11");

    // R10: timeout boundary
    header(mkpid(6'h11));
    send_byte(8'h01);
    send_byte(8'h02);
    for (int k = 0; k < TB_TO - 1; k++) begin
      @(negedge clk); bit_tick = 1;
    end
    @(negedge clk); bit_tick = 0;
    settle("R10");
    expect_ev(K_TO, 6'h11, last_sub, "R10");
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
    settle("R10");

    // R4: frame accepted after the timeout
    sub_frame(6'h10, 2, 1'b0, 64'h0000_0000_0000_0180, 1'b1, "R4");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule